// File: doc/BRIEF.md
# Flash Write-Status Bit Generator

This block sits between a flash array and the host read path. While an internal program or erase runs, a host read of the affected region does not return plain array data: bit 7 carries a polling value, bit 6 flips on every status read, and bit 2 flips when the region is being erased or is erase-suspended. Outside those cases the stored array word passes through untouched. A separate open-drain enable pulls the ready/busy line low while a program or an unsuspended erase is in progress.

The command decoder supplies the operation in progress, the target address, whether an erase is suspended and where, the word being programmed, and a read strobe with its address. The array supplies the stored word for the read address. A region is the set of addresses that share every address bit at or above `REGION_LSB`. Reads are registered: the result appears one clock after the strobe.

Top module: `flash_wstat`

## Requirements
- R1: While reset is asserted and after its release with no read, `rd_vld` is 0, `rd_data` is 0 and `rdy_pull` is 0.
- R2: `rd_vld` is 1 in exactly the cycle after a cycle with `rd_stb` = 1, and `rd_data` then holds the result for that strobe; without a strobe `rd_data` holds its value.
- R3: With `op_kind` = 2'b01 (program), a read in the region of `tgt_addr` returns bit 7 as the inverse of `prog_data[7]`, bit 6 as the bit-6 toggle, and all other bits, bit 2 included, from `arr_data`; a read outside that region returns `arr_data`.
- R4: With `op_kind` = 2'b10 (erase) and `susp_act` = 0, a read in the target region returns bit 7 = 0, bit 6 from the bit-6 toggle and bit 2 from the bit-2 toggle, other bits from `arr_data`.
- R5: Both toggles are 0 after reset; the bit-6 toggle inverts after each read that returns program or active-erase status, so successive such reads alternate starting with 0.
- R6: The bit-2 toggle inverts after each active-erase status read and each suspended-region read, and does not change on program status reads.
- R7: With `susp_act` = 1, a read in the region of `susp_addr` (and not a program status read) returns bit 7 = 1, bit 6 = 1 and bit 2 from the bit-2 toggle; a read elsewhere with no operation hitting it returns `arr_data` unchanged.
- R8: A program started while an erase is suspended (`op_kind` = 2'b01, `susp_act` = 1) returns program status per R3 and holds `rdy_pull` at 1.
- R9: `rdy_pull` is 1 in any cycle where `op_kind` is program, or erase with `susp_act` = 0, and 0 otherwise (including `op_kind` = 2'b00 and 2'b11).
- R10: The toggles change only on cycles with `rd_stb` = 1; idle cycles between reads leave the next status value unaffected.
- R11: With no operation and no suspend, reads return `arr_data` exactly; a read strobed in the same cycle that `op_kind` returns to 2'b00 already returns plain array data, in the cycle `rdy_pull` releases.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| op_kind | input | 2 | 00 none, 01 program, 10 erase, 11 none |
| susp_act | input | 1 | An erase is suspended |
| tgt_addr | input | ADDR_W | Address of the running operation |
| susp_addr | input | ADDR_W | Address inside the suspended region |
| prog_data | input | DATA_W | Word being programmed |
| rd_stb | input | 1 | Host read strobe |
| rd_addr | input | ADDR_W | Host read address |
| arr_data | input | DATA_W | Stored array word at `rd_addr` |
| rd_data | output | DATA_W | Read result, registered |
| rd_vld | output | 1 | `rd_data` updated this cycle |
| rdy_pull | output | 1 | Enable that pulls ready/busy low |

## Verification
A read strobe and the end of an operation can fall in the same cycle, as can a read strobe and a change of suspend state. The bench provokes both by changing `op_kind` or `susp_act` in the very cycle it strobes a read, and judges the returned word against the state present in that cycle: plain array data once the operation has ended, suspended-region status once suspend is set. It also checks that `rdy_pull` releases in that same cycle and that the toggle sequence carries on unbroken into later operations.

// File: rtl/flash_wstat.sv
module flash_wstat #(
  parameter int ADDR_W     = 20,
  parameter int DATA_W     = 16,
  parameter int REGION_LSB = 11
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [1:0]        op_kind,
  input  logic              susp_act,
  input  logic [ADDR_W-1:0] tgt_addr,
  input  logic [ADDR_W-1:0] susp_addr,
  input  logic [DATA_W-1:0] prog_data,
  input  logic              rd_stb,
  input  logic [ADDR_W-1:0] rd_addr,
  input  logic [DATA_W-1:0] arr_data,
  output logic [DATA_W-1:0] rd_data,
  output logic              rd_vld,
  output logic              rdy_pull
);

  localparam logic [1:0] OP_PROG  = 2'b01;
  localparam logic [1:0] OP_ERASE = 2'b10;

  logic is_prog, is_erase, in_tgt, in_susp;
  logic prog_hit, ers_hit, sus_hit;
  logic t6_q, t2_q;
  logic [DATA_W-1:0] nxt;

  assign is_prog  = (op_kind == OP_PROG);
  assign is_erase = (op_kind == OP_ERASE);
  assign in_tgt   = (rd_addr[ADDR_W-1:REGION_LSB] == tgt_addr[ADDR_W-1:REGION_LSB]);
  assign in_susp  = (rd_addr[ADDR_W-1:REGION_LSB] == susp_addr[ADDR_W-1:REGION_LSB]);

  assign prog_hit = is_prog & in_tgt;
  assign ers_hit  = is_erase & ~susp_act & in_tgt;
  assign sus_hit  = susp_act & in_susp & ~prog_hit;

  assign rdy_pull = is_prog | (is_erase & ~susp_act);

  always_comb begin
    nxt = arr_data;
    if (prog_hit) begin
      nxt[7] = ~prog_data[7];
      nxt[6] = t6_q;
    end else if (ers_hit) begin
      nxt[7] = 1'b0;
      nxt[6] = t6_q;
      nxt[2] = t2_q;
    end else if (sus_hit) begin
      nxt[7] = 1'b1;
      nxt[6] = 1'b1;
      nxt[2] = t2_q;
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      rd_data <= '0;
      rd_vld  <= 1'b0;
      t6_q    <= 1'b0;
      t2_q    <= 1'b0;
    end else begin
      rd_vld <= rd_stb;
      if (rd_stb) begin
        rd_data <= nxt;
        t6_q    <= t6_q ^ (prog_hit | ers_hit);
        t2_q    <= t2_q ^ (ers_hit | sus_hit);
      end
    end
  end

  AST_VLD_LATENCY: assert property (@(posedge clk) disable iff (!rst_n)
    rd_stb |=> rd_vld); // R2
  AST_DATA_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    !rd_stb |=> $stable(rd_data)); // R2
  AST_PROG_POLL: assert property (@(posedge clk) disable iff (!rst_n)
    (rd_stb && is_prog && in_tgt) |=> (rd_data[7] == ~$past(prog_data[7]))); // R3
  AST_ERASE_POLL: assert property (@(posedge clk) disable iff (!rst_n)
    (rd_stb && is_erase && !susp_act && in_tgt) |=> (rd_data[7] == 1'b0)); // R4
  AST_T6_FLIP: assert property (@(posedge clk) disable iff (!rst_n)
    (rd_stb && (prog_hit || ers_hit)) |=> (t6_q != $past(t6_q))); // R5
  AST_T2_PROG_KEEP: assert property (@(posedge clk) disable iff (!rst_n)
    (rd_stb && prog_hit) |=> $stable(t2_q)); // R6
  AST_SUSP_FIXED: assert property (@(posedge clk) disable iff (!rst_n)
    (rd_stb && susp_act && in_susp && !(is_prog && in_tgt)) |=> (rd_data[7:6] == 2'b11)); // R7
  AST_NO_READ_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    !rd_stb |=> ($stable(t6_q) && $stable(t2_q))); // R10
  AST_IDLE_PASS: assert property (@(posedge clk) disable iff (!rst_n)
    (rd_stb && !is_prog && !is_erase && !susp_act) |=> (rd_data == $past(arr_data))); // R11

endmodule

// File: tb/flash_wstat_tb_top.sv
module flash_wstat_tb_top;
  localparam int AW = 20;
  localparam int DW = 16;
  localparam int RL = 11;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic [1:0] op_kind = 2'b00;
  logic susp_act = 1'b0;
  logic [AW-1:0] tgt_addr = '0, susp_addr = '0, rd_addr = '0;
  logic [DW-1:0] prog_data = '0, arr_data = '0;
  logic rd_stb = 1'b0;
  logic [DW-1:0] rd_data;
  logic rd_vld, rdy_pull;

  int n_chk = 0, n_fail = 0;
  logic m6 = 1'b0, m2 = 1'b0;
  logic [DW-1:0] exp_q[$];
  string tag_q[$];

  always #2 clk = ~clk;

  flash_wstat #(.ADDR_W(AW), .DATA_W(DW), .REGION_LSB(RL)) dut_i (
    .clk(clk), .rst_n(rst_n), .op_kind(op_kind), .susp_act(susp_act),
    .tgt_addr(tgt_addr), .susp_addr(susp_addr), .prog_data(prog_data),
    .rd_stb(rd_stb), .rd_addr(rd_addr), .arr_data(arr_data),
    .rd_data(rd_data), .rd_vld(rd_vld), .rdy_pull(rdy_pull));

  task automatic chk(input string tag, input logic [DW-1:0] act, input logic [DW-1:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  always @(negedge clk) begin
    if (rst_n && rd_vld) begin
      if (exp_q.size() == 0) chk("R2 unexpected rd_vld", 16'h1, 16'h0);
      else chk(tag_q.pop_front(), rd_data, exp_q.pop_front());
    end
  end

  // driver: drive at negedge, expected value from the requirements
  task automatic rd(input logic [AW-1:0] a, input logic [DW-1:0] arr, input string tag);
    logic [DW-1:0] e;
    logic ph, eh, sh, it, is;
    it = (a[AW-1:RL] == tgt_addr[AW-1:RL]);
    is = (a[AW-1:RL] == susp_addr[AW-1:RL]);
    ph = (op_kind == 2'b01) && it;
    eh = (op_kind == 2'b10) && !susp_act && it;
    sh = susp_act && is && !ph;
    e = arr;
    if (ph) begin e[7] = ~prog_data[7]; e[6] = m6; m6 = ~m6; end
    else if (eh) begin e[7] = 1'b0; e[6] = m6; e[2] = m2; m6 = ~m6; m2 = ~m2; end
    else if (sh) begin e[7] = 1'b1; e[6] = 1'b1; e[2] = m2; m2 = ~m2; end
    rd_addr = a; arr_data = arr; rd_stb = 1'b1;
    exp_q.push_back(e); tag_q.push_back(tag);
    @(negedge clk);
    rd_stb = 1'b0;
  endtask

  task automatic idle(input int n);
    for (int i = 0; i < n; i++) @(negedge clk);
  endtask

  initial begin
    #800000;
    n_fail++;
    $display("FAIL watchdog actual=running expected=done");
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end

  initial begin
    tgt_addr = 20'h01800; susp_addr = 20'h02000;
    idle(3);
    chk("R1 rd_vld in reset", {15'b0, rd_vld}, 16'h0);
    chk("R1 rd_data in reset", rd_data, 16'h0);
    rst_n = 1'b1;
    idle(2);
    chk("R1 rd_vld after reset", {15'b0, rd_vld}, 16'h0);
    chk("R1 rdy_pull after reset", {15'b0, rdy_pull}, 16'h0);
    chk("R1 rd_data after reset", rd_data, 16'h0);

    rd(20'h01800, 16'h1234, "R11 idle pass");
    rd(20'h10000, 16'hFFFF, "R2 R11 idle pass 2");
    idle(2);

    op_kind = 2'b01; prog_data = 16'h00A5;
    @(negedge clk);
    chk("R9 busy on program", {15'b0, rdy_pull}, 16'h1);
    rd(20'h01802, 16'h0F84, "R3 R5 program read 1");
    rd(20'h01802, 16'h0F84, "R3 R5 R6 program read 2");
    rd(20'h01802, 16'h0F84, "R3 R6 program read 3");
    rd(20'h30000, 16'h5A5A, "R3 outside target");
    idle(7);
    rd(20'h01802, 16'h0F84, "R10 after idle cycles");
    prog_data = 16'h0025;
    rd(20'h01804, 16'h0000, "R3 data bit7 zero");
    op_kind = 2'b00;
    #0;
    chk("R11 R9 release same cycle", {15'b0, rdy_pull}, 16'h0);
    rd(20'h01804, 16'h00C4, "R11 read as op ends");

    op_kind = 2'b10; tgt_addr = 20'h02000;
    @(negedge clk);
    chk("R9 busy on erase", {15'b0, rdy_pull}, 16'h1);
    rd(20'h02010, 16'hFFFF, "R4 erase read 1");
    rd(20'h02010, 16'hFFFF, "R4 R6 erase read 2");
    rd(20'h02010, 16'hFFFF, "R4 R6 erase read 3");
    idle(4);
    rd(20'h02010, 16'hFFFF, "R10 erase after idle");

    susp_act = 1'b1;
    #0;
    chk("R9 released on suspend", {15'b0, rdy_pull}, 16'h0);
    rd(20'h02011, 16'h0000, "R7 suspended region as suspend starts");
    rd(20'h02011, 16'h0000, "R7 suspended region 2");
    rd(20'h40000, 16'hBEEF, "R7 outside suspended region");

    op_kind = 2'b01; tgt_addr = 20'h05000; prog_data = 16'h0080;
    @(negedge clk);
    chk("R8 busy program in suspend", {15'b0, rdy_pull}, 16'h1);
    rd(20'h05000, 16'h1111, "R8 program in suspend 1");
    rd(20'h05000, 16'h1111, "R8 program in suspend 2");
    rd(20'h02000, 16'h0000, "R7 R8 suspended region during program");

    op_kind = 2'b10; tgt_addr = 20'h02000;
    rd(20'h02000, 16'h0000, "R7 back to suspend");
    susp_act = 1'b0;
    #0;
    chk("R9 busy on resume", {15'b0, rdy_pull}, 16'h1);
    rd(20'h02000, 16'hFFFF, "R4 after resume");
    op_kind = 2'b11;
    #0;
    chk("R9 reserved code idle", {15'b0, rdy_pull}, 16'h0);
    rd(20'h02000, 16'hFFFF, "R11 reserved code pass");
    op_kind = 2'b00;
    rd(20'h02000, 16'hFFFF, "R11 done");
    idle(3);
    chk("R2 all reads returned", 16'(exp_q.size()), 16'h0);
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end
endmodule